// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Turn-On Dead Time

This block turns three control bits into the four gate commands of a full bridge. The bits are a direction bit from an upstream comparator, a global kill and an enable for the upper switches. Every command that turns a gate on waits through a programmable number of clock cycles before it acts, so a leg never conducts straight through. Commands that turn a gate off act at once. The two upper switches share one delay setting and the two lower switches share another, which lets the two commutation directions be trimmed to match.

Each upper gate also leaves the block as a pair of short pulses meant for a level-shifted latch downstream. A set pulse is sent when the gate turns on and a clear pulse when it turns off. The registered gate state is output alongside the pulses as a mirror of that latch. All inputs are synchronous to `clk` and all outputs come from registers.

Top module: `hbridge_gate_ctl`

## Requirements
- R1: While `rst_n` is low, all eight outputs are 0.
- R2: When `kill_i` is 1 at a clock edge, all four gate outputs are 0 after that edge, whatever the other inputs are.
- R3: With `kill_i`=0, `dir_i`=1 requests A-high and B-low, and `dir_i`=0 requests A-low and B-high. A gate that is not requested is 0 after the edge that samples the input.
- R4: With `hi_en_i`=0, both upper gates stay 0. The requested lower gate still turns on as set by `dir_i`.
- R5: Turning a gate off adds no delay: the gate is 0 after the first edge at which its request is absent.
- R6: Upper gates use `hi_dly_i` and lower gates use `lo_dly_i`. If a gate is requested while the other gate of its leg is already off, the gate goes high after the edge D cycles after the first edge that samples the request, where D is the setting. A setting of 0 therefore gives the minimum one-cycle latency.
- R7: If the other gate of the leg was on, the incoming gate goes high D+1 edges after the edge at which the outgoing gate fell. The upper and lower gate of one leg are never 1 in the same cycle.
- R8: If a request disappears before its delay has expired, the count restarts from zero. The gate stays 0 until a full new delay has passed after the request returns.
- R9: A setting of all ones keeps its group of gates at 0 for as long as the setting is held, and turns off any gate of the group that is on.
- R10: When an upper gate rises, its set output is 1 for PULSE_CYC cycles. When an upper gate falls, its clear output is 1 for PULSE_CYC cycles. A new edge ends a running pulse and starts the pulse of the other kind. Set and clear are never 1 together.
- R11: Each upper gate output equals the state that a latch set by the set pulse and cleared by the clear pulse would hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dir_i | input | 1 | Direction bit that selects the diagonal pair |
| kill_i | input | 1 | Forces every gate off while high |
| hi_en_i | input | 1 | Allows the upper gates to turn on while high |
| hi_dly_i | input | DLY_W | Turn-on delay of the upper gates, in cycles (all ones means never) |
| lo_dly_i | input | DLY_W | Turn-on delay of the lower gates, in cycles (all ones means never) |
| a_hi_o | output | 1 | Leg A upper gate command (latched mirror) |
| a_lo_o | output | 1 | Leg A lower gate command |
| b_hi_o | output | 1 | Leg B upper gate command (latched mirror) |
| b_lo_o | output | 1 | Leg B lower gate command |
| a_hi_set_o | output | 1 | Leg A upper turn-on pulse |
| a_hi_clr_o | output | 1 | Leg A upper turn-off pulse |
| b_hi_set_o | output | 1 | Leg B upper turn-on pulse |
| b_hi_clr_o | output | 1 | Leg B upper turn-off pulse |

## Verification
The bench builds the block with DLY_W=4 and PULSE_CYC=3. With these values the all-ones setting (15) is one value among sixteen, so random traffic applies the never-turn-on setting often. Random hold times of up to about 40 cycles exceed every finite delay, so withdrawals in mid-delay, completed turn-ons and clear pulses that cut short a running set pulse all occur many times. Directed runs measure the exact rise cycle for zero, short and restarted delays.

// File: rtl/hbridge_gate_ctl.sv
module hbridge_gate_ctl #(
  parameter int DLY_W     = 8,
  parameter int PULSE_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_i,
  input  logic             kill_i,
  input  logic             hi_en_i,
  input  logic [DLY_W-1:0] hi_dly_i,
  input  logic [DLY_W-1:0] lo_dly_i,
  output logic             a_hi_o,
  output logic             a_lo_o,
  output logic             b_hi_o,
  output logic             b_lo_o,
  output logic             a_hi_set_o,
  output logic             a_hi_clr_o,
  output logic             b_hi_set_o,
  output logic             b_hi_clr_o
);
  localparam int               PW_W    = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
  localparam logic [PW_W-1:0]  PW_LAST = PW_W'(PULSE_CYC - 1);
  localparam logic [DLY_W-1:0] DLY_INF = '1;

  // gate order: 0 A-high, 1 A-low, 2 B-high, 3 B-low; partner in leg is i^1
  logic [3:0] req, gate, gate_nxt;
  logic [1:0] set_v, clr_v;

  assign req[0] = !kill_i &&  dir_i && hi_en_i;
  assign req[1] = !kill_i && !dir_i;
  assign req[2] = !kill_i && !dir_i && hi_en_i;
  assign req[3] = !kill_i &&  dir_i;

  for (genvar i = 0; i < 4; i++) begin : g_sw
    logic [DLY_W-1:0] dly, cnt;
    logic             on_q, hold_off, nxt;

    assign dly      = ((i % 2) == 0) ? hi_dly_i : lo_dly_i;
    assign hold_off = !req[i] || (dly == DLY_INF);

    always_comb begin
      if (hold_off)         nxt = 1'b0;
      else if (on_q)        nxt = 1'b1;
      else if (gate[i ^ 1]) nxt = 1'b0;
      else                  nxt = (cnt >= dly);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        on_q <= 1'b0;
        cnt  <= '0;
      end else begin
        on_q <= nxt;
        if (hold_off || on_q || gate[i ^ 1] || cnt >= dly) cnt <= '0;
        else                                               cnt <= cnt + 1'b1;
      end
    end

    assign gate[i]     = on_q;
    assign gate_nxt[i] = nxt;
  end

  for (genvar s = 0; s < 2; s++) begin : g_pulse
    logic            set_q, clr_q;
    logic [PW_W-1:0] left;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        set_q <= 1'b0;
        clr_q <= 1'b0;
        left  <= '0;
      end else if (gate_nxt[2*s] && !gate[2*s]) begin
        set_q <= 1'b1;
        clr_q <= 1'b0;
        left  <= PW_LAST;
      end else if (!gate_nxt[2*s] && gate[2*s]) begin
        set_q <= 1'b0;
        clr_q <= 1'b1;
        left  <= PW_LAST;
      end else if (left != '0) begin
        left  <= left - 1'b1;
      end else begin
        set_q <= 1'b0;
        clr_q <= 1'b0;
      end
    end

    assign set_v[s] = set_q;
    assign clr_v[s] = clr_q;
  end

  assign a_hi_o     = gate[0];
  assign a_lo_o     = gate[1];
  assign b_hi_o     = gate[2];
  assign b_lo_o     = gate[3];
  assign a_hi_set_o = set_v[0];
  assign a_hi_clr_o = clr_v[0];
  assign b_hi_set_o = set_v[1];
  assign b_hi_clr_o = clr_v[1];
endmodule

// File: rtl/hbridge_gate_ctl_chk.sv
module hbridge_gate_ctl_chk #(
  parameter int DLY_W     = 8,
  parameter int PULSE_CYC = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dir_i,
  input logic             kill_i,
  input logic             hi_en_i,
  input logic [DLY_W-1:0] hi_dly_i,
  input logic [DLY_W-1:0] lo_dly_i,
  input logic             a_hi_o,
  input logic             a_lo_o,
  input logic             b_hi_o,
  input logic             b_lo_o,
  input logic             a_hi_set_o,
  input logic             a_hi_clr_o,
  input logic             b_hi_set_o,
  input logic             b_hi_clr_o
);
  localparam logic [DLY_W-1:0] DLY_INF = '1;

  int unsigned a_run, b_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_run <= 0;
      b_run <= 0;
    end else begin
      a_run <= a_hi_set_o ? a_run + 1 : 0;
      b_run <= b_hi_set_o ? b_run + 1 : 0;
    end
  end

  p_reset_r1: assert property (@(posedge clk) !rst_n |=> (!a_hi_o && !a_lo_o && !b_hi_o && !b_lo_o) || !rst_n);

  p_kill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    kill_i |=> !a_hi_o && !a_lo_o && !b_hi_o && !b_lo_o);

  p_diag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dir_i |=> !a_lo_o && !b_hi_o);

  p_diag_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_i |=> !a_hi_o && !b_lo_o);

  p_hien_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_en_i |=> !a_hi_o && !b_hi_o);

  p_leg_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_hi_o && a_lo_o) && !(b_hi_o && b_lo_o));

  p_gap_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a_lo_o) |-> !$past(a_hi_o));

  p_gap_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(b_hi_o) |-> !$past(b_lo_o));

  p_inf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_dly_i == DLY_INF) |=> !a_hi_o && !b_hi_o);

  p_inf_lo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_dly_i == DLY_INF) |=> !a_lo_o && !b_lo_o);

  p_excl_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_hi_set_o && a_hi_clr_o) && !(b_hi_set_o && b_hi_clr_o));

  p_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
    a_run <= PULSE_CYC && b_run <= PULSE_CYC);

  p_rise_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a_hi_o) |-> a_hi_set_o);

  p_fall_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(b_hi_o) |-> b_hi_clr_o);

  p_mirror_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (a_hi_set_o |-> a_hi_o) and (a_hi_clr_o |-> !a_hi_o) and
    (b_hi_set_o |-> b_hi_o) and (b_hi_clr_o |-> !b_hi_o));
endmodule

bind hbridge_gate_ctl hbridge_gate_ctl_chk #(.DLY_W(DLY_W), .PULSE_CYC(PULSE_CYC)) u_chk (.*);

// File: tb/hbridge_gate_ctl_tb_top.sv
module hbridge_gate_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW  = 4;
  localparam int PC  = 3;
  localparam int INF = (1 << DW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dir_i = 1'b0, kill_i = 1'b1, hi_en_i = 1'b1;
  logic [DW-1:0] hi_dly_i = '0, lo_dly_i = '0;
  logic a_hi_o, a_lo_o, b_hi_o, b_lo_o;
  logic a_hi_set_o, a_hi_clr_o, b_hi_set_o, b_hi_clr_o;

  int nchk = 0, nerr = 0;

  hbridge_gate_ctl #(.DLY_W(DW), .PULSE_CYC(PC)) dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // expected-value model
  bit [3:0] m_g;
  int       m_cnt [4];
  bit [1:0] m_set, m_clr;
  int       m_left [2];

  function automatic bit wanted(int i);
    if (kill_i) return 0;
    case (i)
      0: return dir_i && hi_en_i;
      1: return !dir_i;
      2: return !dir_i && hi_en_i;
      default: return dir_i;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_g = '0; m_set = '0; m_clr = '0;
      for (int i = 0; i < 4; i++) m_cnt[i] = 0;
      for (int s = 0; s < 2; s++) m_left[s] = 0;
    end else begin
      bit [3:0] ng;
      for (int i = 0; i < 4; i++) begin
        int d;
        d = (i % 2 == 0) ? int'(hi_dly_i) : int'(lo_dly_i);
        if (!wanted(i) || d == INF) begin ng[i] = 0; m_cnt[i] = 0; end
        else if (m_g[i])            begin ng[i] = 1; m_cnt[i] = 0; end
        else if (m_g[i ^ 1])        begin ng[i] = 0; m_cnt[i] = 0; end
        else if (m_cnt[i] >= d)     begin ng[i] = 1; m_cnt[i] = 0; end
        else                        begin ng[i] = 0; m_cnt[i]++;    end
      end
      for (int s = 0; s < 2; s++) begin
        if (ng[2*s] && !m_g[2*s])      begin m_set[s] = 1; m_clr[s] = 0; m_left[s] = PC - 1; end
        else if (!ng[2*s] && m_g[2*s]) begin m_set[s] = 0; m_clr[s] = 1; m_left[s] = PC - 1; end
        else if (m_left[s] != 0)       m_left[s]--;
        else                           begin m_set[s] = 0; m_clr[s] = 0; end
      end
      m_g = ng;
    end
  end

  task automatic chk(string tag, string nm, logic act, bit exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic step(string tag);
    @(negedge clk);
    chk(tag, "a_hi", a_hi_o, m_g[0]);
    chk(tag, "a_lo", a_lo_o, m_g[1]);
    chk(tag, "b_hi", b_hi_o, m_g[2]);
    chk(tag, "b_lo", b_lo_o, m_g[3]);
    chk("R10", "a_set", a_hi_set_o, m_set[0]);
    chk("R10", "a_clr", a_hi_clr_o, m_clr[0]);
    chk("R11", "b_set", b_hi_set_o, m_set[1]);
    chk("R11", "b_clr", b_hi_clr_o, m_clr[1]);
  endtask

  task automatic steps(string tag, int n);
    for (int k = 0; k < n; k++) step(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nchk++; nerr++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    steps("R1", 3);
    chk("R1", "all_low", a_hi_o | a_lo_o | b_hi_o | b_lo_o | a_hi_set_o | a_hi_clr_o | b_hi_set_o | b_hi_clr_o, 1'b0);
    rst_n = 1'b1;
    steps("R2", 3);

    // R6: idle leg, upper 3, lower 2
    hi_dly_i = 4'd3; lo_dly_i = 4'd2; dir_i = 1'b1; kill_i = 1'b0;
    for (int n = 1; n <= 6; n++) begin
      step("R6");
      chk("R6", "a_hi_rise", a_hi_o, n >= 4);
      chk("R6", "b_lo_rise", b_lo_o, n >= 3);
      chk("R3", "a_lo_off", a_lo_o, 1'b0);
    end

    // R5/R7/R10: commutate to the other diagonal
    dir_i = 1'b0;
    for (int n = 1; n <= 8; n++) begin
      step("R7");
      chk("R5", "a_hi_off", a_hi_o, 1'b0);
      chk("R5", "b_lo_off", b_lo_o, 1'b0);
      chk("R7", "a_lo_dead", a_lo_o, n >= 4);
      chk("R7", "b_hi_dead", b_hi_o, n >= 5);
      chk("R10", "a_clr_pulse", a_hi_clr_o, n <= 3);
      chk("R10", "b_set_pulse", b_hi_set_o, n >= 5 && n <= 7);
    end

    // R2: kill with gates on
    kill_i = 1'b1;
    step("R2");
    chk("R2", "kill_all", a_hi_o | a_lo_o | b_hi_o | b_lo_o, 1'b0);
    steps("R2", 4);

    // R8: withdraw a pending lower turn-on, then re-request
    lo_dly_i = 4'd5; dir_i = 1'b0; kill_i = 1'b0;
    steps("R8", 3);
    kill_i = 1'b1;
    step("R8");
    kill_i = 1'b0;
    for (int n = 1; n <= 7; n++) begin
      step("R8");
      chk("R8", "a_lo_restart", a_lo_o, n >= 6);
    end

    // R4: upper enable low
    hi_en_i = 1'b0; dir_i = 1'b1; lo_dly_i = 4'd0; hi_dly_i = 4'd0;
    for (int n = 1; n <= 6; n++) begin
      step("R4");
      chk("R4", "uppers_off", a_hi_o | b_hi_o, 1'b0);
      chk("R4", "b_lo_on", b_lo_o, n >= 2);
    end

    // R9: infinite upper delay, then while an upper gate is on
    hi_en_i = 1'b1; hi_dly_i = 4'(INF);
    for (int n = 1; n <= 20; n++) begin
      if (n == 10) dir_i = 1'b0;
      step("R9");
      chk("R9", "uppers_held", a_hi_o | b_hi_o, 1'b0);
    end
    hi_dly_i = 4'd0;
    steps("R9", 3);
    chk("R9", "b_hi_after", b_hi_o, 1'b1);
    hi_dly_i = 4'(INF);
    step("R9");
    chk("R9", "b_hi_forced_off", b_hi_o, 1'b0);

    // random traffic
    for (int seg = 0; seg < 2500; seg++) begin
      int hold;
      string tg;
      kill_i  = ($urandom_range(0, 9) == 0);
      hi_en_i = ($urandom_range(0, 5) != 0);
      dir_i   = $urandom_range(0, 1);
      if ($urandom_range(0, 3) == 0) hi_dly_i = 4'($urandom_range(0, INF));
      if ($urandom_range(0, 3) == 0) lo_dly_i = 4'($urandom_range(0, INF));
      hold = ($urandom_range(0, 2) == 0) ? $urandom_range(1, 40) : $urandom_range(1, 6);
      tg = kill_i ? "R2" : (!hi_en_i ? "R4" : "R3");
      steps(tg, hold);
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule